// File: doc/BRIEF.md
# Configuration Space Access Engine

This block accepts configuration-space requests of one, two or four bytes, each addressed by a bus number, device number, function number and register offset. It carries each one out on a back-end bus that only knows full 32-bit reads and writes. A narrow read fetches the whole dword and returns the selected lanes. A narrow write fetches the dword, replaces the selected lanes and stores the whole dword again. A four-byte write goes straight to the store.

The back end works in one of two modes, chosen per request by `winMode`. In port mode the engine first writes a packed address, with its enable bit set, to an address register, and then moves data through a data register. In window mode the packed address selects a dword directly inside a memory-mapped region, and the address register is never touched.

Only one request is handled at a time. `reqReady` stays low from acceptance until the response cycle, so each read-modify-write is atomic from the requester's point of view.

Top module: `cfg_space_engine`

## Requirements
- R1: After reset `reqReady` is 1 and both `rspValid` and `busReq` are 0.
- R2: In port mode the first bus access of a request is a write to dword index `ADDR_PORT_IDX` (default 0x40) with value 0x8000_0000 | bus<<16 | device<<11 | function<<8 | (offset with bits 1:0 cleared). Data accesses then go to index `DATA_PORT_IDX` (default 0x41).
- R3: In port mode a narrow write (size code 0 = byte, 1 = halfword) issues exactly four bus accesses in this order: address write, data read, address write again, data write.
- R4: A read returns the fetched dword shifted right by 8 × (offset mod 4). A byte read keeps the low 8 bits and a halfword read keeps the low 16 bits, zero-extended. A dword read (size code 2) returns the dword unchanged.
- R5: A narrow write stores the fetched dword with lane (0xFF or 0xFFFF) << 8 × (offset mod 4) cleared and the masked data shifted into it. Bits shifted beyond bit 31 are dropped.
- R6: A dword write performs no bus read and stores exactly the request data.
- R7: A request is rejected when the offset exceeds 255 (byte), 254 (halfword) or 252 (dword), or when the size code is 3. A rejected request makes no bus access and answers with `rspErr` = 1 and `rspData` = 0.
- R8: In window mode (`winMode` = 1) every bus access uses dword index `WIN_BASE_IDX` (default 0x10_0000) + packed address / 4, and no address-register write occurs.
- R9: `reqReady` is 0 from the cycle after acceptance through the response cycle and returns to 1 in the next cycle. `rspValid` lasts exactly one cycle.
- R10: `busReq`, `busWrite`, `busAddr` and `busWData` hold steady until the cycle in which `busAck` is seen.
- R11: A successful write answers with `rspErr` = 0 and `rspData` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| winMode | input | 1 | Back-end mode for the request being accepted: 1 window, 0 port |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle and able to accept |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 dword, 3 reserved |
| reqBus | input | 8 | Bus number |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOff | input | 12 | Register byte offset |
| reqWData | input | 32 | Write data, right-aligned |
| rspValid | output | 1 | Response cycle |
| rspErr | output | 1 | Request rejected |
| rspData | output | 32 | Read result, right-aligned |
| busReq | output | 1 | Back-end access pending |
| busWrite | output | 1 | Back-end access is a write |
| busAddr | output | 32 | Back-end dword index |
| busWData | output | 32 | Back-end write dword |
| busRData | input | 32 | Back-end read dword |
| busAck | input | 1 | Back-end access completes in this cycle |

## Verification
Issuing a bus access and completing it can fall in the same cycle. The bench's back-end model cycles through zero, one and two wait cycles, so some acknowledges arrive in the first cycle of a request and others only after the request has been held. The model checks at each acknowledge that address and data are unchanged since the request first appeared, and it logs the access. The log is compared with the access sequence the bench predicts for the mode, width and offset. A behavioural storage copy predicts every read result and every merged dword.

// File: rtl/cfg_engine_pkg.sv
package cfg_engine_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    BSEL_NONE = 2'd0,
    BSEL_ADDR = 2'd1,
    BSEL_DATA = 2'd2
  } busSel_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR1 = 3'd1,
    ST_READ  = 3'd2,
    ST_ADDR2 = 3'd3,
    ST_WRITE = 3'd4,
    ST_RESP  = 3'd5
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    capture;
    busSel_e sel;
  } ctlStrobe_t;

  // classification of a request, from datapath to control
  typedef struct packed {
    logic err;
    logic write;
    logic full;
    logic win;
  } reqKind_t;

endpackage

// File: rtl/cfg_engine_dp.sv
module cfg_engine_dp
  import cfg_engine_pkg::*;
#(
  parameter int CFG_BYTES = 256,
  parameter int OFF_W = 12,
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W = 3,
  parameter int BADDR_W = 32,
  parameter logic [BADDR_W-1:0] ADDR_PORT_IDX = 32'h40,
  parameter logic [BADDR_W-1:0] DATA_PORT_IDX = 32'h41,
  parameter logic [BADDR_W-1:0] WIN_BASE_IDX = 32'h0010_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic               winMode,
  input  logic               reqWrite,
  input  logic [1:0]         reqSize,
  input  logic [BUS_W-1:0]   reqBus,
  input  logic [DEV_W-1:0]   reqDev,
  input  logic [FN_W-1:0]    reqFunc,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [31:0]        reqWData,
  input  logic [31:0]        busRData,
  output reqKind_t           inKind,
  output reqKind_t           curKind,
  output logic [BADDR_W-1:0] busAddr,
  output logic [31:0]        busWData,
  output logic [31:0]        rspData
);

  localparam int REG_W = $clog2(CFG_BYTES);
  localparam int PACK_W = BUS_W + DEV_W + FN_W + REG_W;
  localparam logic [OFF_W-1:0] LIM_BYTE = OFF_W'(CFG_BYTES - 1);
  localparam logic [OFF_W-1:0] LIM_HALF = OFF_W'(CFG_BYTES - 2);
  localparam logic [OFF_W-1:0] LIM_WORD = OFF_W'(CFG_BYTES - 4);
  localparam logic [31:0] ENABLE_BIT = 32'h8000_0000;

  reqKind_t         rKind;
  logic [1:0]       rSize;
  logic [BUS_W-1:0] rBus;
  logic [DEV_W-1:0] rDev;
  logic [FN_W-1:0]  rFunc;
  logic [REG_W-1:0] rOff;
  logic [31:0]      rWData;
  logic [31:0]      rdWord;

  logic [31:0] packedAddr;
  logic [4:0]  laneShift;
  logic [31:0] sizeMask;
  logic [31:0] laneMask;
  logic [31:0] newLanes;
  logic [31:0] mergedWord;
  logic [31:0] pickedLanes;
  logic        offTooFar;

  // range check on the incoming request
  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: offTooFar = reqOff > LIM_BYTE;
      SZ_HALF: offTooFar = reqOff > LIM_HALF;
      SZ_WORD: offTooFar = reqOff > LIM_WORD;
      default: offTooFar = 1'b1;
    endcase
  end

  assign inKind = '{err:   offTooFar,
                    write: reqWrite,
                    full:  reqSize == SZ_WORD,
                    win:   winMode};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rKind  <= '0;
      rSize  <= '0;
      rBus   <= '0;
      rDev   <= '0;
      rFunc  <= '0;
      rOff   <= '0;
      rWData <= '0;
      rdWord <= '0;
    end else begin
      if (ctl.load) begin
        rKind  <= inKind;
        rSize  <= reqSize;
        rBus   <= reqBus;
        rDev   <= reqDev;
        rFunc  <= reqFunc;
        rOff   <= reqOff[REG_W-1:0];
        rWData <= reqWData;
        rdWord <= '0;
      end
      if (ctl.capture) begin
        rdWord <= busRData;
      end
    end
  end

  assign curKind = rKind;

  assign packedAddr = 32'({rBus, rDev, rFunc, rOff[REG_W-1:2], 2'b00});
  assign laneShift = {rOff[1:0], 3'b000};

  always_comb begin
    unique case (accSize_e'(rSize))
      SZ_BYTE: sizeMask = 32'h0000_00FF;
      SZ_HALF: sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  end

  // lane merge for a read-modify-write
  assign laneMask = sizeMask << laneShift;
  assign newLanes = (rWData & sizeMask) << laneShift;
  assign mergedWord = rKind.full ? rWData : ((rdWord & ~laneMask) | newLanes);

  // lane pick for a read
  assign pickedLanes = rKind.full ? rdWord : ((rdWord >> laneShift) & sizeMask);
  assign rspData = (rKind.write || rKind.err) ? 32'h0 : pickedLanes;

  // back-end address and data
  always_comb begin
    busAddr  = DATA_PORT_IDX;
    busWData = mergedWord;
    if (ctl.sel == BSEL_ADDR) begin
      busAddr  = ADDR_PORT_IDX;
      busWData = ENABLE_BIT | packedAddr;
    end else if (rKind.win) begin
      busAddr = WIN_BASE_IDX + BADDR_W'(packedAddr >> 2);
    end
  end

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    rKind.err |-> ctl.sel == BSEL_NONE) else $error("error request reached bus"); // R7

endmodule

// File: rtl/cfg_engine_ctl.sv
module cfg_engine_ctl
  import cfg_engine_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busAck,
  input  reqKind_t   inKind,
  input  reqKind_t   curKind,
  output logic       reqReady,
  output logic       busReq,
  output logic       busWrite,
  output logic       rspValid,
  output ctlStrobe_t ctl
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '{load: 1'b0, capture: 1'b0, sel: BSEL_NONE};
    busReq    = 1'b0;
    busWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load = 1'b1;
          if (inKind.err)                      stateNext = ST_RESP;
          else if (!inKind.win)                stateNext = ST_ADDR1;
          else if (inKind.write && inKind.full) stateNext = ST_WRITE;
          else                                  stateNext = ST_READ;
        end
      end
      ST_ADDR1: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        ctl.sel  = BSEL_ADDR;
        if (busAck) stateNext = (curKind.write && curKind.full) ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        busReq      = 1'b1;
        ctl.sel     = BSEL_DATA;
        ctl.capture = busAck;
        if (busAck) begin
          if (!curKind.write)   stateNext = ST_RESP;
          else if (curKind.win) stateNext = ST_WRITE;
          else                  stateNext = ST_ADDR2;
        end
      end
      ST_ADDR2: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        ctl.sel  = BSEL_ADDR;
        if (busAck) stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        ctl.sel  = BSEL_DATA;
        if (busAck) stateNext = ST_RESP;
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = state == ST_IDLE;
  assign rspValid = state == ST_RESP;

  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busReq && !rspValid) else $error("ready while busy"); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady) else $error("response not a pulse"); // R9
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busWrite)) else $error("bus request dropped"); // R10
  AST_ERR_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && inKind.err |=> rspValid && !busReq) else $error("error not answered at once"); // R7

endmodule

// File: rtl/cfg_space_engine.sv
module cfg_space_engine
  import cfg_engine_pkg::*;
#(
  parameter int CFG_BYTES = 256,
  parameter int OFF_W = 12,
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W = 3,
  parameter int BADDR_W = 32,
  parameter logic [BADDR_W-1:0] ADDR_PORT_IDX = 32'h40,
  parameter logic [BADDR_W-1:0] DATA_PORT_IDX = 32'h41,
  parameter logic [BADDR_W-1:0] WIN_BASE_IDX = 32'h0010_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winMode,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [1:0]         reqSize,
  input  logic [BUS_W-1:0]   reqBus,
  input  logic [DEV_W-1:0]   reqDev,
  input  logic [FN_W-1:0]    reqFunc,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [31:0]        reqWData,
  output logic               rspValid,
  output logic               rspErr,
  output logic [31:0]        rspData,
  output logic               busReq,
  output logic               busWrite,
  output logic [BADDR_W-1:0] busAddr,
  output logic [31:0]        busWData,
  input  logic [31:0]        busRData,
  input  logic               busAck
);

  ctlStrobe_t ctl;
  reqKind_t   inKind;
  reqKind_t   curKind;

  cfg_engine_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busAck   (busAck),
    .inKind   (inKind),
    .curKind  (curKind),
    .reqReady (reqReady),
    .busReq   (busReq),
    .busWrite (busWrite),
    .rspValid (rspValid),
    .ctl      (ctl)
  );

  cfg_engine_dp #(
    .CFG_BYTES     (CFG_BYTES),
    .OFF_W         (OFF_W),
    .BUS_W         (BUS_W),
    .DEV_W         (DEV_W),
    .FN_W          (FN_W),
    .BADDR_W       (BADDR_W),
    .ADDR_PORT_IDX (ADDR_PORT_IDX),
    .DATA_PORT_IDX (DATA_PORT_IDX),
    .WIN_BASE_IDX  (WIN_BASE_IDX)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .winMode  (winMode),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqBus   (reqBus),
    .reqDev   (reqDev),
    .reqFunc  (reqFunc),
    .reqOff   (reqOff),
    .reqWData (reqWData),
    .busRData (busRData),
    .inKind   (inKind),
    .curKind  (curKind),
    .busAddr  (busAddr),
    .busWData (busWData),
    .rspData  (rspData)
  );

  assign rspErr = rspValid && curKind.err;

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busAddr) && $stable(busWData)) else $error("bus fields moved"); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspData == 32'h0) else $error("error response carries data"); // R7

endmodule

// File: tb/cfg_space_engine_test.sv
module cfg_space_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_IDX = 32'h40;
  localparam logic [31:0] D_IDX = 32'h41;
  localparam logic [31:0] W_BASE = 32'h0010_0000;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
  } busOp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        winMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [11:0] reqOff = '0;
  logic [31:0] reqWData = '0;
  logic        rspValid, rspErr;
  logic [31:0] rspData;
  logic        busReq, busWrite;
  logic [31:0] busAddr, busWData;
  logic [31:0] busRData = '0;
  logic        busAck = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] slaveMem [int];
  logic [31:0] refMem [int];
  logic [31:0] addrLatch = '0;
  busOp_t obsQ[$];
  busOp_t expQ[$];
  int waitCnt = 0;
  int opCount = 0;
  bit seen = 0;
  logic [31:0] holdA, holdD;

  cfg_space_engine uut (
    .clk(clk), .rstN(rstN), .winMode(winMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc),
    .reqOff(reqOff), .reqWData(reqWData),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .busAck(busAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] initVal(int k);
    return (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // back-end model: variable wait, logs every completed access
  always @(negedge clk) begin
    if (busAck) begin
      busAck = 1'b0;
      waitCnt = opCount % 3;
    end else if (busReq) begin
      if (!seen) begin
        seen = 1;
        holdA = busAddr;
        holdD = busWData;
      end
      if (waitCnt > 0) begin
        waitCnt--;
      end else begin
        chk(busAddr == holdA && (!busWrite || busWData == holdD), "R10 held fields",
            busAddr, holdA);
        seen = 0;
        opCount++;
        if (busWrite) begin
          if (busAddr == A_IDX) addrLatch = busWData;
          else if (busAddr == D_IDX) slaveMem[int'(addrLatch[23:2])] = busWData;
          else slaveMem[int'(busAddr - W_BASE)] = busWData;
          obsQ.push_back('{wr: 1'b1, addr: busAddr, data: busWData});
        end else begin
          int k;
          k = (busAddr == D_IDX) ? int'(addrLatch[23:2]) : int'(busAddr - W_BASE);
          if (busAddr == D_IDX && !addrLatch[31]) busRData = 32'hFFFF_FFFF;
          else busRData = slaveMem.exists(k) ? slaveMem[k] : initVal(k);
          obsQ.push_back('{wr: 1'b0, addr: busAddr, data: 32'h0});
        end
        busAck = 1'b1;
      end
    end
  end

  task automatic doReq(string tag, bit win, bit wr, logic [1:0] sz, logic [7:0] b,
                       logic [4:0] d, logic [2:0] f, logic [11:0] off, logic [31:0] wd);
    bit expErr;
    logic [31:0] packed_, key, old, sm, res, expData, aval, dAddr;
    int sh, cyc;
    expErr = (sz == 2'd3) || (sz == 2'd0 && off > 255) || (sz == 2'd1 && off > 254) ||
             (sz == 2'd2 && off > 252);
    packed_ = {8'h0, b, d, f, off[7:2], 2'b00};
    key = packed_ >> 2;
    sh = 8 * int'(off[1:0]);
    old = refMem.exists(int'(key)) ? refMem[int'(key)] : initVal(int'(key));
    sm = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    aval = 32'h8000_0000 | packed_;
    dAddr = win ? W_BASE + key : D_IDX;
    expData = 32'h0;
    if (!expErr) begin
      if (!wr) expData = (sz == 2'd2) ? old : ((old >> sh) & sm);
      if (wr) begin
        res = (sz == 2'd2) ? wd : ((old & ~(sm << sh)) | ((wd & sm) << sh));
        refMem[int'(key)] = res;
      end
      if (!win) expQ.push_back('{wr: 1'b1, addr: A_IDX, data: aval});
      if (!(wr && sz == 2'd2)) expQ.push_back('{wr: 1'b0, addr: dAddr, data: 32'h0});
      if (wr && sz != 2'd2 && !win) expQ.push_back('{wr: 1'b1, addr: A_IDX, data: aval});
      if (wr) expQ.push_back('{wr: 1'b1, addr: dAddr, data: res});
    end
    @(negedge clk);
    chk(reqReady == 1'b1, {tag, " R9 ready before request"}, 32'(reqReady), 32'h1);
    winMode = win; reqWrite = wr; reqSize = sz; reqBus = b; reqDev = d; reqFunc = f;
    reqOff = off; reqWData = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!rspValid && cyc < 60) begin
      chk(reqReady == 1'b0, {tag, " R9 busy"}, 32'(reqReady), 32'h0);
      @(negedge clk);
      cyc++;
    end
    chk(rspValid == 1'b1, {tag, " R9 response seen"}, 32'(rspValid), 32'h1);
    chk(reqReady == 1'b0, {tag, " R9 busy in response cycle"}, 32'(reqReady), 32'h0);
    chk(rspErr == expErr, {tag, " rspErr"}, 32'(rspErr), 32'(expErr));
    chk(rspData == expData, {tag, " rspData"}, rspData, expData);
    chk(obsQ.size() == expQ.size(), {tag, " access count"}, 32'(obsQ.size()), 32'(expQ.size()));
    if (obsQ.size() == expQ.size()) begin
      for (int i = 0; i < expQ.size(); i++) begin
        chk(obsQ[i].wr == expQ[i].wr && obsQ[i].addr == expQ[i].addr,
            {tag, " access kind/index"}, obsQ[i].addr, expQ[i].addr);
        if (expQ[i].wr)
          chk(obsQ[i].data == expQ[i].data, {tag, " access data"}, obsQ[i].data, expQ[i].data);
      end
    end
    obsQ.delete();
    expQ.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready", 32'(reqReady), 32'h1);
    chk(rspValid == 1'b0, "R1 rspValid", 32'(rspValid), 32'h0);
    chk(busReq == 1'b0, "R1 busReq", 32'(busReq), 32'h0);

    // port mode reads
    doReq("R2 R4 port dword read", 0, 0, 2'd2, 8'h01, 5'd3, 3'd2, 12'h010, 32'h0);
    doReq("R4 port byte read lane1", 0, 0, 2'd0, 8'h01, 5'd3, 3'd2, 12'h011, 32'h0);
    doReq("R4 port byte read lane3", 0, 0, 2'd0, 8'h01, 5'd3, 3'd2, 12'h013, 32'h0);
    doReq("R4 port half read lane2", 0, 0, 2'd1, 8'hA5, 5'd31, 3'd7, 12'h012, 32'h0);
    doReq("R4 port half read lane3 truncated", 0, 0, 2'd1, 8'hA5, 5'd31, 3'd7, 12'h013, 32'h0);
    // port mode writes
    doReq("R3 R5 R11 port byte write", 0, 1, 2'd0, 8'h02, 5'd4, 3'd1, 12'h021, 32'hFFFF_FFAB);
    doReq("R5 port read back", 0, 0, 2'd2, 8'h02, 5'd4, 3'd1, 12'h020, 32'h0);
    doReq("R3 R5 port half write lane3", 0, 1, 2'd1, 8'h02, 5'd4, 3'd1, 12'h023, 32'h0000_BEEF);
    doReq("R5 port read back 2", 0, 0, 2'd2, 8'h02, 5'd4, 3'd1, 12'h020, 32'h0);
    doReq("R6 R11 port dword write", 0, 1, 2'd2, 8'h07, 5'd0, 3'd0, 12'h030, 32'h1234_5678);
    doReq("R6 port read back", 0, 0, 2'd0, 8'h07, 5'd0, 3'd0, 12'h032, 32'h0);
    // range limits
    doReq("R7 byte off 255 accepted", 0, 0, 2'd0, 8'h03, 5'd1, 3'd0, 12'd255, 32'h0);
    doReq("R7 byte off 256 rejected", 0, 0, 2'd0, 8'h03, 5'd1, 3'd0, 12'd256, 32'h0);
    doReq("R7 half off 254 accepted", 0, 1, 2'd1, 8'h03, 5'd1, 3'd0, 12'd254, 32'h0000_C0DE);
    doReq("R7 half off 255 rejected", 0, 1, 2'd1, 8'h03, 5'd1, 3'd0, 12'd255, 32'h0000_C0DE);
    doReq("R7 dword off 252 accepted", 0, 0, 2'd2, 8'h03, 5'd1, 3'd0, 12'd252, 32'h0);
    doReq("R7 dword off 253 rejected", 0, 1, 2'd2, 8'h03, 5'd1, 3'd0, 12'd253, 32'hDEAD_BEEF);
    doReq("R7 reserved size rejected", 0, 0, 2'd3, 8'h03, 5'd1, 3'd0, 12'd0, 32'h0);
    doReq("R7 far offset rejected", 1, 0, 2'd0, 8'h03, 5'd1, 3'd0, 12'hFFF, 32'h0);
    // window mode
    doReq("R8 window dword read", 1, 0, 2'd2, 8'h10, 5'd5, 3'd3, 12'h040, 32'h0);
    doReq("R8 R5 window byte write", 1, 1, 2'd0, 8'h10, 5'd5, 3'd3, 12'h042, 32'h0000_005A);
    doReq("R8 R4 window half read", 1, 0, 2'd1, 8'h10, 5'd5, 3'd3, 12'h041, 32'h0);
    doReq("R8 R6 window dword write", 1, 1, 2'd2, 8'hFF, 5'd31, 3'd7, 12'h0FC, 32'hCAFE_F00D);
    doReq("R8 window read back", 1, 0, 2'd2, 8'hFF, 5'd31, 3'd7, 12'h0FC, 32'h0);
    // same storage seen through both modes
    doReq("R2 R8 port view of window write", 0, 0, 2'd2, 8'h10, 5'd5, 3'd3, 12'h040, 32'h0);
    for (int i = 0; i < 8; i++) begin
      doReq("R5 mixed byte writes", i[0], 1, 2'd0, 8'h20, 5'd2, 3'd1, 12'(8'h60 + i), 32'(i * 17));
    end
    doReq("R5 mixed read back", 0, 0, 2'd2, 8'h20, 5'd2, 3'd1, 12'h060, 32'h0);
    doReq("R5 mixed read back hi", 1, 0, 2'd2, 8'h20, 5'd2, 3'd1, 12'h064, 32'h0);

    @(negedge clk);
    chk(reqReady == 1'b1, "R9 idle at end", 32'(reqReady), 32'h1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule